// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Bank

This block gathers 64 interrupt request lines into two processor-facing outputs, a normal request `irq_out` and a fast request `fiq_out`. Each line is configured as edge-triggered or level-sensitive. An edge line is caught in a per-source latch on the chosen edge, which is rising, falling or both. A level line is passed straight through with a chosen active polarity. A per-source software trigger can raise any line. Each line has an enable mask and a route select that sends it to one of the two outputs.

Software reaches the block over a plain 32-bit register bus. The bus has a word address, a write strobe, write data and combinational read data. Each 64-bit register is split into a low word (sources 0 to 31) and a high word (sources 32 to 63) at adjacent addresses. A handler reads the masked status words and takes the lowest set bit, low word first, as the interrupt number. It then clears the edge latch with a write-1 access. Inputs are taken as synchronous to `clk`.

Top module: `intc_regbank`

## Requirements
- R1: Synchronous active-low reset sets every enable, soft trigger, route select and edge latch to 0 and holds both outputs low. The sense, dual-edge and polarity registers take the parameter values `SENSE_INIT`, `DUAL_INIT` and `POL_INIT`.
- R2: The register index is `bus_addr[7:3]` and `bus_addr[2]` picks the word (0 = sources 0–31, 1 = sources 32–63). The offsets are: 0x00 IRQ status, 0x08 FIQ status, 0x10 raw status, 0x18 route select, 0x20 enable set, 0x28 enable clear, 0x30 trigger set, 0x38 trigger clear, 0x40 sense, 0x48 dual edge, 0x50 polarity, 0x58 latch clear, 0x60 latch status. The clear offsets 0x28, 0x38 and 0x58 read 0. Offsets 0x68 and above read 0. Writes to the status offsets and to the undecoded offsets change nothing.
- R3: Writing 1s at 0x20 sets enable bits and writing 1s at 0x28 clears them. Zero bits leave enables unchanged. The enable register reads back at 0x20.
- R4: Writing 1s at 0x30 sets soft trigger bits and writing 1s at 0x38 clears them. Triggers read back at 0x30. Raw status at 0x10 is the OR of the source activity and the trigger.
- R5: A route select bit of 0 sends the source to IRQ status (0x00 = raw AND enable AND NOT select). A select bit of 1 sends it to FIQ status (0x08 = raw AND enable AND select).
- R6: A source with sense bit 0 is edge-triggered. Its polarity bit 1 latches a rising edge and 0 latches a falling edge. An edge is seen against the input sampled at the previous clock edge. The latch sets at the clock edge that first samples the new input level, and it shows at 0x60 and in raw status.
- R7: A dual-edge bit of 1 on an edge source latches both edges, whatever its polarity bit says.
- R8: A source with sense bit 1 is level-sensitive. It is active while the input equals its polarity bit, combinationally and without latching. Its latch status bit reads 0.
- R9: Writing 1s at 0x58 clears edge latches and 0 bits have no effect. Such a write does not change a level source. An edge detected in the same cycle as the clear wins, and the latch stays set.
- R10: `irq_out` is the OR of all IRQ status bits and `fiq_out` is the OR of all FIQ status bits, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wen | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| src_in | input | 64 | Interrupt request lines, synchronous to `clk` |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
A long stretch mixes random writes to every offset with random toggling of the request lines. This exercises sense, polarity, dual edge, routing, enable and trigger in combinations that no directed case lists. Directed cases separate the detection styles. Rising and falling polarity on the same line tells edge selection apart from simple change detection. A dual-edge line in the high word shows that the polarity bit is ignored and that the word select works. An active-low level line shows pass-through with no latching, and that a latch clear leaves it alone. A clear written in the same cycle as a new edge shows that set has priority over clear. After every step the bench reads back every offset and both outputs. A fault in one word, one register or one route therefore shows up on its own offset.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
// Shared constants for the interrupt controller register bank.
// Register index values are the address bits [7:3]; software depends on them.
package intc_pkg;
    localparam int unsigned SRC_N  = 64;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned IDX_W  = ADDR_W - 3;

    typedef logic [SRC_N-1:0]  srcvec_t;
    typedef logic [WORD_W-1:0] word_t;

    localparam logic [IDX_W-1:0] IX_IRQ = 5'd0;
    localparam logic [IDX_W-1:0] IX_FIQ = 5'd1;
    localparam logic [IDX_W-1:0] IX_RAW = 5'd2;
    localparam logic [IDX_W-1:0] IX_SEL = 5'd3;
    localparam logic [IDX_W-1:0] IX_ENS = 5'd4;
    localparam logic [IDX_W-1:0] IX_ENC = 5'd5;
    localparam logic [IDX_W-1:0] IX_TRS = 5'd6;
    localparam logic [IDX_W-1:0] IX_TRC = 5'd7;
    localparam logic [IDX_W-1:0] IX_SNS = 5'd8;
    localparam logic [IDX_W-1:0] IX_DUA = 5'd9;
    localparam logic [IDX_W-1:0] IX_POL = 5'd10;
    localparam logic [IDX_W-1:0] IX_ECL = 5'd11;
    localparam logic [IDX_W-1:0] IX_EST = 5'd12;

    // Replace one 32-bit word of a 64-bit register.
    function automatic srcvec_t put_word(srcvec_t old, logic hi, word_t w);
        return hi ? {w, old[WORD_W-1:0]} : {old[SRC_N-1:WORD_W], w};
    endfunction

    // Place a 32-bit write mask into the chosen word of a 64-bit vector.
    function automatic srcvec_t word_mask(logic hi, word_t w);
        return hi ? {w, {WORD_W{1'b0}}} : {{WORD_W{1'b0}}, w};
    endfunction
endpackage

// File: rtl/intc_cfg_regs.sv
`timescale 1ns/1ps
// Configuration register file: enables, soft triggers, route select,
// sense, dual-edge and polarity, plus a one-cycle latch-clear strobe.
// Assumes one bus write per cycle; status and undecoded indices are ignored.
module intc_cfg_regs
    import intc_pkg::*;
#(
    parameter srcvec_t SENSE_INIT = '0,
    parameter srcvec_t DUAL_INIT  = '0,
    parameter srcvec_t POL_INIT   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wen,
    input  logic [IDX_W-1:0] idx,
    input  logic             hi,
    input  word_t            wdata,
    output srcvec_t          en_q,
    output srcvec_t          trig_q,
    output srcvec_t          sel_q,
    output srcvec_t          sense_q,
    output srcvec_t          dual_q,
    output srcvec_t          pol_q,
    output srcvec_t          eclr
);
    srcvec_t wmask;

    // Spread the write data into the addressed word.
    always_comb wmask = word_mask(hi, wdata);

    // Latch-clear strobe, active only in the cycle of the write.
    always_comb eclr = (wen && idx == IX_ECL) ? wmask : '0;

    // Register updates: write-1 set/clear pairs and plain word writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            trig_q  <= '0;
            sel_q   <= '0;
            sense_q <= SENSE_INIT;
            dual_q  <= DUAL_INIT;
            pol_q   <= POL_INIT;
        end else if (wen) begin
            case (idx)
                IX_ENS:  en_q    <= en_q | wmask;
                IX_ENC:  en_q    <= en_q & ~wmask;
                IX_TRS:  trig_q  <= trig_q | wmask;
                IX_TRC:  trig_q  <= trig_q & ~wmask;
                IX_SEL:  sel_q   <= put_word(sel_q, hi, wdata);
                IX_SNS:  sense_q <= put_word(sense_q, hi, wdata);
                IX_DUA:  dual_q  <= put_word(dual_q, hi, wdata);
                IX_POL:  pol_q   <= put_word(pol_q, hi, wdata);
                default: ;
            endcase
        end
    end

    assert_en_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && idx == IX_ENS && !hi) |=> ((en_q[WORD_W-1:0] & $past(wdata)) == $past(wdata)));
    assert_en_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && idx == IX_ENC && hi) |=> ((en_q[SRC_N-1:WORD_W] & $past(wdata)) == '0));
    assert_trig_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && idx == IX_TRS && !hi) |=> ((trig_q[WORD_W-1:0] & $past(wdata)) == $past(wdata)));
endmodule

// File: rtl/intc_src_cell.sv
`timescale 1ns/1ps
// One request line: edge detection against the previous sample with a
// set-priority latch, or level pass-through with selectable polarity.
// Assumes src is synchronous to clk.
module intc_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic sense,
    input  logic dual,
    input  logic pol,
    input  logic clr,
    output logic latch_q,
    output logic active
);
    logic prev_q;
    logic rise;
    logic fall;
    logic det;

    // Edge detection against the previous sample.
    always_comb begin
        rise = src & ~prev_q;
        fall = ~src & prev_q;
        det  = dual ? (rise | fall) : (pol ? rise : fall);
    end

    // Previous sample and the edge latch; a new edge beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            prev_q <= src;
            if (sense)       latch_q <= 1'b0;
            else if (det)    latch_q <= 1'b1;
            else if (clr)    latch_q <= 1'b0;
        end
    end

    // Source activity: level compare or latched edge.
    always_comb active = sense ? (src == pol) : latch_q;

    assert_edge_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense && det) |=> latch_q);
    assert_edge_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense && clr && !det) |=> !latch_q);
endmodule

// File: rtl/intc_status_rd.sv
`timescale 1ns/1ps
// Status merge and read multiplexer: raw, masked IRQ/FIQ status, the two
// request outputs and the combinational bus read data.
module intc_status_rd
    import intc_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic             hi,
    input  srcvec_t          en_q,
    input  srcvec_t          trig_q,
    input  srcvec_t          sel_q,
    input  srcvec_t          sense_q,
    input  srcvec_t          dual_q,
    input  srcvec_t          pol_q,
    input  srcvec_t          latch_q,
    input  srcvec_t          active,
    output word_t            rdata,
    output logic             irq_out,
    output logic             fiq_out
);
    srcvec_t raw;
    srcvec_t irq_st;
    srcvec_t fiq_st;
    srcvec_t view;

    // Merge activity with triggers and apply enable and routing.
    always_comb begin
        raw     = active | trig_q;
        irq_st  = raw & en_q & ~sel_q;
        fiq_st  = raw & en_q & sel_q;
        irq_out = |irq_st;
        fiq_out = |fiq_st;
    end

    // Select the addressed register, then the addressed word.
    always_comb begin
        case (idx)
            IX_IRQ:  view = irq_st;
            IX_FIQ:  view = fiq_st;
            IX_RAW:  view = raw;
            IX_SEL:  view = sel_q;
            IX_ENS:  view = en_q;
            IX_TRS:  view = trig_q;
            IX_SNS:  view = sense_q;
            IX_DUA:  view = dual_q;
            IX_POL:  view = pol_q;
            IX_EST:  view = latch_q;
            default: view = '0;
        endcase
        rdata = hi ? view[SRC_N-1:WORD_W] : view[WORD_W-1:0];
    end
endmodule

// File: rtl/intc_regbank.sv
`timescale 1ns/1ps
// Interrupt controller register bank, top level. 64 request lines, each
// edge-latched or level-passed, enabled and routed to irq_out or fiq_out.
// Assumes src_in is synchronous to clk and one bus access per cycle.
module intc_regbank
    import intc_pkg::*;
#(
    parameter srcvec_t SENSE_INIT = '0,
    parameter srcvec_t DUAL_INIT  = '0,
    parameter srcvec_t POL_INIT   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [SRC_N-1:0]  src_in,
    output logic              irq_out,
    output logic              fiq_out
);
    logic [IDX_W-1:0] idx;
    logic             hi;
    srcvec_t en_q, trig_q, sel_q, sense_q, dual_q, pol_q, eclr;
    srcvec_t latch_q, active;

    // Address split: register index and word select.
    always_comb begin
        idx = bus_addr[ADDR_W-1:3];
        hi  = bus_addr[2];
    end

    intc_cfg_regs #(
        .SENSE_INIT(SENSE_INIT),
        .DUAL_INIT (DUAL_INIT),
        .POL_INIT  (POL_INIT)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wen    (bus_wen),
        .idx    (idx),
        .hi     (hi),
        .wdata  (bus_wdata),
        .en_q   (en_q),
        .trig_q (trig_q),
        .sel_q  (sel_q),
        .sense_q(sense_q),
        .dual_q (dual_q),
        .pol_q  (pol_q),
        .eclr   (eclr)
    );

    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        intc_src_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .src    (src_in[g]),
            .sense  (sense_q[g]),
            .dual   (dual_q[g]),
            .pol    (pol_q[g]),
            .clr    (eclr[g]),
            .latch_q(latch_q[g]),
            .active (active[g])
        );
    end

    intc_status_rd u_rd (
        .idx    (idx),
        .hi     (hi),
        .en_q   (en_q),
        .trig_q (trig_q),
        .sel_q  (sel_q),
        .sense_q(sense_q),
        .dual_q (dual_q),
        .pol_q  (pol_q),
        .latch_q(latch_q),
        .active (active),
        .rdata  (bus_rdata),
        .irq_out(irq_out),
        .fiq_out(fiq_out)
    );

    assert_quiet_when_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(|en_q) |-> (!irq_out && !fiq_out));
    assert_sel_routing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(|sel_q) |-> !fiq_out);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0 && trig_q == '0 && latch_q == '0));
endmodule

// File: tb/intc_regbank_tb.sv
`timescale 1ns/1ps
// Self-checking bench: a reference model driven by the requirements,
// directed corner cases, then seeded random stimulus.
module intc_regbank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] src_in = '0;
    logic        irq_out, fiq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [63:0] m_en, m_trig, m_sel, m_sense, m_dual, m_pol, m_latch, m_prev;

    intc_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
        .irq_out(irq_out), .fiq_out(fiq_out)
    );

    always #10 clk = ~clk;

    function automatic logic [63:0] m_raw();
        logic [63:0] act;
        act = (m_sense & ~(src_in ^ m_pol)) | (~m_sense & m_latch);
        return act | m_trig;
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        logic [63:0] v;
        case (a[7:3])
            5'd0:  v = m_raw() & m_en & ~m_sel;
            5'd1:  v = m_raw() & m_en & m_sel;
            5'd2:  v = m_raw();
            5'd3:  v = m_sel;
            5'd4:  v = m_en;
            5'd6:  v = m_trig;
            5'd8:  v = m_sense;
            5'd9:  v = m_dual;
            5'd10: v = m_pol;
            5'd12: v = m_latch;
            default: v = '0;
        endcase
        return a[2] ? v[63:32] : v[31:0];
    endfunction

    function automatic string req_of(logic [4:0] ix);
        case (ix)
            5'd0, 5'd1, 5'd3: return "R5";
            5'd2, 5'd6:       return "R4";
            5'd4:             return "R3";
            5'd8, 5'd10:      return "R8";
            5'd9:             return "R7";
            5'd12:            return "R6";
            default:          return "R2";
        endcase
    endfunction

    // Advance the model by one clock edge with the currently driven inputs.
    task automatic model_clock();
        logic [63:0] rise, fall, det, clr, wm;
        wm   = bus_addr[2] ? {bus_wdata, 32'h0} : {32'h0, bus_wdata};
        rise = src_in & ~m_prev;
        fall = ~src_in & m_prev;
        det  = (m_dual & (rise | fall)) | (~m_dual & m_pol & rise) | (~m_dual & ~m_pol & fall);
        clr  = (bus_wen && bus_addr[7:3] == 5'd11) ? wm : '0;
        m_latch = ~m_sense & (det | (m_latch & ~clr));
        m_prev  = src_in;
        if (bus_wen) begin
            case (bus_addr[7:3])
                5'd4:  m_en   = m_en | wm;
                5'd5:  m_en   = m_en & ~wm;
                5'd6:  m_trig = m_trig | wm;
                5'd7:  m_trig = m_trig & ~wm;
                5'd3:  m_sel   = bus_addr[2] ? {bus_wdata, m_sel[31:0]}   : {m_sel[63:32], bus_wdata};
                5'd8:  m_sense = bus_addr[2] ? {bus_wdata, m_sense[31:0]} : {m_sense[63:32], bus_wdata};
                5'd9:  m_dual  = bus_addr[2] ? {bus_wdata, m_dual[31:0]}  : {m_dual[63:32], bus_wdata};
                5'd10: m_pol   = bus_addr[2] ? {bus_wdata, m_pol[31:0]}   : {m_pol[63:32], bus_wdata};
                default: ;
            endcase
        end
    endtask

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Compare both outputs and every offset; a non-empty tag overrides.
    task automatic check_all(string tag);
        logic [63:0] r;
        r = m_raw();
        check(tag == "" ? "R10" : tag, "irq_out", {31'b0, irq_out}, {31'b0, |(r & m_en & ~m_sel)});
        check(tag == "" ? "R10" : tag, "fiq_out", {31'b0, fiq_out}, {31'b0, |(r & m_en & m_sel)});
        for (int a = 0; a < 128; a += 4) begin
            bus_addr = a[7:0];
            #0.05;
            check(tag == "" ? req_of(bus_addr[7:3]) : tag, $sformatf("read %02h", a),
                  bus_rdata, m_read(bus_addr));
        end
    endtask

    // Drive one clock cycle, optionally with a write, ending at a falling edge.
    task automatic tick(bit w, logic [7:0] a, logic [31:0] d);
        bus_wen = w; bus_addr = a; bus_wdata = d;
        model_clock();
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual still running, expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_en = '0; m_trig = '0; m_sel = '0; m_sense = '0; m_dual = '0;
        m_pol = '0; m_latch = '0; m_prev = '0;
        repeat (3) @(negedge clk);
        // R1: reset state, observed while reset is still held
        check_all("R1");
        rst_n = 1'b1;
        // R1: still quiet after release
        check_all("R1");

        // R3: write-1 set, zero write ignored, write-1 clear
        tick(1, 8'h20, 32'h0000_0005); check_all("R3");
        tick(1, 8'h20, 32'h0000_0000); check_all("R3");
        tick(1, 8'h28, 32'h0000_0001); check_all("R3");

        // R6: rising edge on source 2 latches and raises irq
        tick(1, 8'h50, 32'h0000_0004);
        src_in[2] = 1'b1; check_all("R6");
        tick(0, 8'h00, 0); check_all("R6");
        src_in[2] = 1'b0; tick(0, 8'h00, 0); check_all("R6");

        // R9: latch clear, then a clear racing a new edge (edge wins)
        tick(1, 8'h58, 32'h0000_0004); check_all("R9");
        src_in[2] = 1'b1; tick(1, 8'h58, 32'h0000_0004); check_all("R9");

        // R7 and R5: dual edge on source 40, routed to fiq
        tick(1, 8'h4c, 32'h0000_0100);
        tick(1, 8'h24, 32'h0000_0100);
        tick(1, 8'h1c, 32'h0000_0100);
        src_in[40] = 1'b1; tick(0, 8'h00, 0); check_all("R7");
        tick(1, 8'h5c, 32'h0000_0100); check_all("R7");
        src_in[40] = 1'b0; tick(0, 8'h00, 0); check_all("R7");

        // R8: active-low level on source 10, and a latch clear leaves it alone (R9)
        tick(1, 8'h40, 32'h0000_0400);
        tick(1, 8'h20, 32'h0000_0400);
        check_all("R8");
        src_in[10] = 1'b1; check_all("R8");
        src_in[10] = 1'b0; tick(1, 8'h58, 32'h0000_0400); check_all("R9");

        // R4: soft trigger on source 63
        tick(1, 8'h24, 32'h8000_0000);
        tick(1, 8'h34, 32'h8000_0000); check_all("R4");
        tick(1, 8'h3c, 32'h8000_0000); check_all("R4");

        // R2: writes to status and undecoded offsets are ignored
        tick(1, 8'h00, 32'hffff_ffff); check_all("R2");
        tick(1, 8'h70, 32'hffff_ffff); check_all("R2");

        // Random mix of writes and input toggles
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            logic [31:0] d;
            src_in = src_in ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
            check_all("");
            a = {$urandom_range(0, 13)[4:0], $urandom_range(0, 1)[0], 2'b00};
            d = $urandom & $urandom;
            tick($urandom_range(0, 2) != 0, a, d);
            check_all("");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule